// File: doc/BRIEF.md
# Phase-Alignable Integer Clock Divider

This block divides its input clock by a programmable whole number between one and eight. Its output is a divided clock, or, when used as a clock enable, a divided enable. Several copies of the block can be driven from the same alignment strobe. Each copy returns its divider to a fixed starting phase when it honors a strobe edge, so that all copies sample in step.

Software-style writes reach two small registers through one write port. The register at address 0 holds the division setting. The register at address 1 holds the alignment control. The alignment strobe can be disabled, honored on every edge, or honored only once after each control write. An output flag shows whether a one-time alignment is still waiting. A new division setting is held back until a safe moment, so the output never emits a shortened pulse.

Top module: `phase_sync_divider`

## Requirements
- R1: A write with `cfg_addr_i`=0 stores `cfg_wdata_i[2:0]` as N-1. Value 0 selects divide-by-1 and value 7 selects divide-by-8. In steady state `div_clk_o` repeats every N input cycles.
- R2: For N>1, `div_clk_o` stays high for ceil(N/2) input cycles and then low for floor(N/2) input cycles. For N=1 it stays high every cycle.
- R3: `sync_i` passes through two flip-flops clocked by `clk_i`. Only a low-to-high change counts as an event, so holding it high for several cycles gives exactly one event.
- R4: A write with `cfg_addr_i`=1 sets the control register. In that register, bit 0 = alignment enable and bit 1 = once-only mode. While bit 0 is 0, every `sync_i` edge is ignored.
- R5: A control write with both bits set to 1 sets `armed_o`. In once-only mode only the first event after that write is honored, and it clears `armed_o`. Later events leave the output untouched until the next control write. A control write without both bits set clears `armed_o`.
- R6: On the clock edge that honors an event, the counter returns to its start phase and `div_clk_o` goes low. It rises on the following edge, which is the fourth rising `clk_i` edge after `sync_i` rises. This holds in every ratio.
- R7: A new division setting takes effect only at the end of the current output period or at the next honored event, whichever comes first.
- R8: When a control write and a synchronized event fall in the same cycle, the event is judged with the control settings held before the write. `armed_o` afterwards reflects the write.
- R9: Two copies with the same ratio that honor a common `sync_i` edge produce identical outputs from then on, whatever their phases were before.
- R10: After `rst_ni` is released, the state is: `div_clk_o` low, `armed_o` low, ratio divide-by-1, alignment disabled. `div_clk_o` rises on the first clock edge after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock to be divided |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sync_i | input | 1 | Alignment strobe, asynchronous to clk_i |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 1 | Register select: 0 ratio, 1 control |
| cfg_wdata_i | input | 3 | Write data |
| div_clk_o | output | 1 | Divided clock / enable |
| armed_o | output | 1 | A once-only alignment is pending |

## Verification
The delicate overlap is a control-register write that lands in the same cycle as a synchronized strobe event. The new settings could decide whether that event is honored, or the event could clear the arm bit that the write has just set. The bench provokes this by timing its write to the third clock edge after raising `sync_i`, once in once-only mode with the arm bit already consumed and once while switching from every-edge mode to disabled. It judges the result from the old-settings rule through a cycle-accurate arithmetic model of both copies. The same model also covers a ratio write that arrives in the middle of a period, which lands either at a period wrap or at a strobe.

// File: rtl/phase_sync_divider_pkg.sv
package phase_sync_divider_pkg;

  // Number of input cycles the divided output stays high for a stored
  // ratio value m1 (division factor m1+1): ceil((m1+1)/2).
  function automatic int unsigned high_len(input int unsigned m1);
    return (m1 >> 1) + 1;
  endfunction

  // Register select values on the write port.
  localparam logic ADDR_RATIO = 1'b0;
  localparam logic ADDR_CTRL  = 1'b1;

endpackage

// File: rtl/div_sync_edge.sv
module div_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sync_i,
  output logic evt_o
);
  logic [STAGES-1:0] chain_q;
  logic              last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= '0;
      last_q  <= 1'b0;
    end else begin
      chain_q[0] <= sync_i;
      for (int k = 1; k < STAGES; k++) chain_q[k] <= chain_q[k-1];
      last_q <= chain_q[STAGES-1];
    end
  end

  assign evt_o = chain_q[STAGES-1] & ~last_q;

  // An event is a single-cycle pulse even for a held strobe.
  assert_evt_single_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_o |=> !evt_o);

endmodule

// File: rtl/div_ctrl.sv
module div_ctrl
  import phase_sync_divider_pkg::*;
#(
  parameter int RATIO_W = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic               addr_i,
  input  logic [RATIO_W-1:0] wdata_i,
  input  logic               evt_i,
  output logic [RATIO_W-1:0] pend_o,
  output logic               armed_o,
  output logic               honor_o
);
  logic               en_q, once_q, armed_q;
  logic [RATIO_W-1:0] pend_q;
  logic               ctl_wr, ratio_wr;

  assign ctl_wr   = we_i & (addr_i == ADDR_CTRL);
  assign ratio_wr = we_i & (addr_i == ADDR_RATIO);
  // Judged with the settings held before any write in this cycle.
  assign honor_o  = evt_i & en_q & (~once_q | armed_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= 1'b0;
      once_q  <= 1'b0;
      armed_q <= 1'b0;
      pend_q  <= '0;
    end else begin
      if (ratio_wr) pend_q <= wdata_i;
      if (ctl_wr) begin
        en_q    <= wdata_i[0];
        once_q  <= wdata_i[1];
        armed_q <= wdata_i[0] & wdata_i[1];
      end else if (honor_o && once_q) begin
        armed_q <= 1'b0;
      end
    end
  end

  assign pend_o  = pend_q;
  assign armed_o = armed_q;

  // A consumed once-only event clears the arm flag.
  assert_arm_consumed_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (honor_o && once_q && !ctl_wr) |=> !armed_o);
  // The arm flag is only ever raised by a control write.
  assert_arm_source_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(armed_o) |-> $past(ctl_wr));
  // A disabled strobe never produces an honored event.
  assert_disabled_ignored_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_q |-> !honor_o);

endmodule

// File: rtl/div_phase_ctr.sv
module div_phase_ctr
  import phase_sync_divider_pkg::*;
#(
  parameter int RATIO_W = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               honor_i,
  input  logic [RATIO_W-1:0] pend_i,
  output logic               div_o,
  output logic               wrap_o
);
  logic [RATIO_W-1:0] cnt_q, act_q, cnt_d, act_d;
  logic               out_q, out_d;

  assign wrap_o = (cnt_q == act_q);

  always_comb begin
    act_d = act_q;
    cnt_d = cnt_q;
    out_d = out_q;
    if (honor_i) begin
      act_d = pend_i;
      cnt_d = pend_i;     // start phase: next edge wraps
      out_d = 1'b0;
    end else if (wrap_o) begin
      act_d = pend_i;
      cnt_d = '0;
      out_d = 1'b1;       // high_len is never zero
    end else begin
      cnt_d = cnt_q + 1'b1;
      out_d = (32'(cnt_q) + 32'd1) < high_len(32'(act_q));
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= '0;
      cnt_q <= '0;
      out_q <= 1'b0;
    end else begin
      act_q <= act_d;
      cnt_q <= cnt_d;
      out_q <= out_d;
    end
  end

  assign div_o = out_q;

  // Honored event puts the divider in its start phase with output low.
  assert_sync_start_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    honor_i |=> (!div_o && wrap_o));
  // Fixed latency: output rises on the edge after the honoring one.
  assert_sync_rise_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    honor_i |=> ##1 div_o);
  // Ratio only changes at a wrap or an honored event.
  assert_ratio_held_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!honor_i && !wrap_o) |=> $stable(act_q));
  // Counter never runs past the active period.
  assert_cnt_bound_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= act_q);

endmodule

// File: rtl/phase_sync_divider.sv
module phase_sync_divider #(
  parameter int RATIO_W     = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sync_i,
  input  logic               cfg_we_i,
  input  logic               cfg_addr_i,
  input  logic [RATIO_W-1:0] cfg_wdata_i,
  output logic               div_clk_o,
  output logic               armed_o
);
  logic               sync_evt;
  logic               sync_honor;
  logic [RATIO_W-1:0] ratio_pend;
  logic               period_wrap;

  div_sync_edge #(.STAGES(SYNC_STAGES)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sync_i (sync_i),
    .evt_o  (sync_evt)
  );

  div_ctrl #(.RATIO_W(RATIO_W)) u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .addr_i  (cfg_addr_i),
    .wdata_i (cfg_wdata_i),
    .evt_i   (sync_evt),
    .pend_o  (ratio_pend),
    .armed_o (armed_o),
    .honor_o (sync_honor)
  );

  div_phase_ctr #(.RATIO_W(RATIO_W)) u_ctr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .honor_i (sync_honor),
    .pend_i  (ratio_pend),
    .div_o   (div_clk_o),
    .wrap_o  (period_wrap)
  );

  // A wrap without an honored event always restarts the high phase.
  assert_wrap_high_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (period_wrap && !sync_honor) |=> div_clk_o);

endmodule

// File: tb/sim_phase_sync_divider.sv
module sim_phase_sync_divider;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       sync0 = 1'b0, sync1 = 1'b0;
  logic       we = 1'b0, addr = 1'b0;
  logic [2:0] wdata = '0;
  logic       out0, out1, arm0, arm1;

  phase_sync_divider u0 (.clk_i(clk), .rst_ni(rst_n), .sync_i(sync0),
    .cfg_we_i(we), .cfg_addr_i(addr), .cfg_wdata_i(wdata),
    .div_clk_o(out0), .armed_o(arm0));
  phase_sync_divider u1 (.clk_i(clk), .rst_ni(rst_n), .sync_i(sync1),
    .cfg_we_i(we), .cfg_addr_i(addr), .cfg_wdata_i(wdata),
    .div_clk_o(out1), .armed_o(arm1));

  always #(CLK_PERIOD/2) clk = ~clk;

  int    total = 0, bad = 0;
  bit    done = 0;
  string tag = "R10";

  // Arithmetic reference for both copies, written from the requirements.
  bit m_s1[2], m_s2[2], m_s3[2], m_en[2], m_once[2], m_arm[2], m_out[2];
  int m_pend[2], m_act[2], m_cnt[2];

  task automatic model_reset();
    for (int i = 0; i < 2; i++) begin
      m_s1[i] = 0; m_s2[i] = 0; m_s3[i] = 0; m_en[i] = 0; m_once[i] = 0;
      m_arm[i] = 0; m_out[i] = 0; m_pend[i] = 0; m_act[i] = 0; m_cnt[i] = 0;
    end
  endtask

  task automatic model_step();
    for (int i = 0; i < 2; i++) begin
      bit sv, ev, hon;
      int old_pend;
      sv  = (i == 0) ? sync0 : sync1;
      ev  = m_s2[i] && !m_s3[i];
      hon = ev && m_en[i] && (!m_once[i] || m_arm[i]);
      old_pend = m_pend[i];
      if (we && addr) begin
        m_en[i] = wdata[0]; m_once[i] = wdata[1]; m_arm[i] = wdata[0] && wdata[1];
      end else if (hon && m_once[i]) m_arm[i] = 0;
      if (we && !addr) m_pend[i] = wdata;
      if (hon) begin
        m_act[i] = old_pend; m_cnt[i] = old_pend; m_out[i] = 0;
      end else if (m_cnt[i] == m_act[i]) begin
        m_act[i] = old_pend; m_cnt[i] = 0; m_out[i] = 1;
      end else begin
        m_cnt[i] = m_cnt[i] + 1;
        m_out[i] = (m_cnt[i] < (m_act[i] + 2) / 2);
      end
      m_s3[i] = m_s2[i]; m_s2[i] = m_s1[i]; m_s1[i] = sv;
    end
  endtask

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic cycle();
    model_step();
    @(posedge clk);
    @(negedge clk);
    chk(out0 == m_out[0], tag, "u0 div_clk_o", out0, m_out[0]);
    chk(out1 == m_out[1], tag, "u1 div_clk_o", out1, m_out[1]);
    chk(arm0 == m_arm[0], tag, "u0 armed_o", arm0, m_arm[0]);
    chk(arm1 == m_arm[1], tag, "u1 armed_o", arm1, m_arm[1]);
  endtask

  task automatic wr(input bit a, input int d);
    we = 1; addr = a; wdata = d[2:0];
    cycle();
    we = 0;
  endtask

  task automatic run(input int n);
    for (int k = 0; k < n; k++) cycle();
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    bad++; total++;
    $display("FAIL watchdog actual=0 expected=1");
    finish_up();
  end

  initial begin
    model_reset();
    #(CLK_PERIOD * 2);
    @(negedge clk);
    // R10: state while held in reset
    chk(out0 == 0, "R10", "reset div_clk_o", out0, 0);
    chk(arm0 == 0, "R10", "reset armed_o", arm0, 0);
    rst_n = 1;
    tag = "R10";
    cycle();
    chk(out0 == 1, "R10", "first rise after release", out0, 1);
    tag = "R2"; run(3);

    // R1 R2 R6 R3: sweep every ratio, every-edge mode, held strobe
    wr(1, 1);
    for (int r = 0; r < 8; r++) begin
      tag = "R1";
      wr(0, r);
      sync0 = 1; sync1 = 1;
      cycle(); cycle(); cycle();
      chk(out0 == 0, "R6", "low on honoring edge", out0, 0);
      cycle();
      chk(out0 == 1, "R6", "rise on fourth edge", out0, 1);
      tag = "R3"; run(3);           // still held high: no second event
      sync0 = 0; sync1 = 0;
      tag = "R2"; run(3 * (r + 1) + 2);
    end

    // R7: ratio change mid-period lands at wrap
    tag = "R7";
    wr(0, 3); run(3);
    wr(0, 2); run(14);
    wr(0, 6); run(2);
    sync0 = 1; run(3); sync0 = 0;   // honored before wrap: new ratio now
    run(16);

    // R4: disabled alignment ignores strobe
    tag = "R4";
    wr(1, 0);
    sync0 = 1; sync1 = 1; run(4); sync0 = 0; sync1 = 0; run(12);

    // R5: once-only mode
    tag = "R5";
    wr(0, 4);
    wr(1, 3);
    chk(arm0 == 1, "R5", "armed after write", arm0, 1);
    sync0 = 1; run(4); sync0 = 0; run(3);
    chk(arm0 == 0, "R5", "armed cleared by event", arm0, 0);
    chk(arm1 == 1, "R5", "other copy still armed", arm1, 1);
    sync0 = 1; run(4); sync0 = 0; run(10);   // ignored

    // R8: control write coincides with event (old settings judged)
    tag = "R8";
    sync0 = 1; cycle(); cycle();
    wr(1, 3);                       // event at this edge, old arm = 0
    chk(arm0 == 1, "R8", "armed after colliding write", arm0, 1);
    sync0 = 0; run(9);
    wr(1, 1);
    sync0 = 1; cycle(); cycle();
    wr(1, 0);                       // old enable = 1: honored
    chk(out0 == 0, "R8", "event honored under old enable", out0, 0);
    sync0 = 0; run(9);

    // R9: two copies brought into phase by a common strobe
    tag = "R9";
    wr(1, 1);
    wr(0, 5);
    sync0 = 1; run(3); sync1 = 1; run(4); sync0 = 0; sync1 = 0; run(6);
    sync0 = 1; sync1 = 1; run(4); sync0 = 0; sync1 = 0;
    for (int k = 0; k < 14; k++) begin
      cycle();
      chk(out0 == out1, "R9", "copies aligned", out0, out1);
    end

    finish_up();
  end
endmodule